// File: doc/BRIEF.md
# Output-Compare Channel Bank

This block holds a small set of independent compare channels that watch a free-running time counter supplied from outside. Each channel has a control word and a compare word, both reached over a simple word-addressed write port and a combinational read port. When the counter value presented in a cycle equals a channel's armed compare value and the channel's mode is not off, the channel raises its event flag and drives its output pin. In toggle mode the pin inverts. In pulse mode the pin goes high for one cycle. An interrupt line per channel is high while the flag and that channel's interrupt enable are both set.

The compare word has two slots. The first write after the channel is emptied arms the active match value. The next write queues the following one. When a match occurs, the queued value takes over as the active value. This lets software keep a steady train of events going, for example a once-per-second pulse whose consecutive targets differ by 1,000,000,000 modulo the counter range. To do this, software writes the value after next each time a match occurs. A global register reflects all channel flags in one word. Writing the mode field to zero empties both slots, so the intended sequence is to clear the mode, confirm it reads back as zero, arm the first value, set the mode, and then queue the second value.

Top module: `cmp_bank`

## Requirements
- R1: After reset every register reads 0, and all pins and interrupt lines are low.
- R2: The register map is as follows. The global flag register is at byte address 0x00, with the flag of channel n in bit n. The control word of channel n is at 0x08+8n and its compare word at 0x0C+8n. In the control word, bit 7 is the event flag, bit 6 is the interrupt enable, bits [5:2] are the mode, and all other bits read 0. The compare word reads the armed active value, or 0 when nothing is armed.
- R3: A value written to a compare word is masked to the 31-bit counter width.
- R4: Compare writes fill the two slots in order. A write to an empty channel arms the active slot. A write while the active slot is armed fills or overwrites the queued slot. On a match, the queued value becomes active, or the channel becomes empty if nothing is queued. An empty channel never matches.
- R5: Any control write with mode 0 empties both slots and clears the pin. While the mode is 0, no match occurs and the flag is not set. Compare writes are still accepted while the mode is 0.
- R6: A match in a cycle sets the event flag at the end of that cycle. Writing 1 to bit 7 of the control word clears the flag. If a match and a clear fall in the same cycle, the flag ends up set.
- R7: In mode 0xF, the pin is high for exactly the one cycle that follows a match.
- R8: In mode 0x5, the pin inverts on each match and holds its level otherwise.
- R9: A channel's interrupt line is high exactly when its flag and its interrupt enable are both set.
- R10: If a compare write lands in the same cycle as a match and no value is queued, the written value becomes the new active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 31 | Time counter value after this cycle's increment |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_o | output | 4 | Per-channel compare output pins |
| irq_o | output | 4 | Per-channel interrupt lines |

## Verification
A register write and a match can fall in the same cycle, and that is where the double buffer and the flag logic are most likely to fail. The bench provokes this by presenting the compare value on the counter input in the same cycle that it drives a compare write into a channel with an empty queue. It then reads back which value is active and checks that the channel matches it later. It also presents a match in the same cycle as a flag-clear write and checks that the flag stays set. A sweep across every channel runs a pulse train with one-second spacing that crosses the counter wrap, and checks each pulse position and each hand-over from the queued slot to the active slot against targets that the bench computes itself.

// File: rtl/cmpbank_pkg.sv
package cmpbank_pkg;
  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;

  localparam int BIT_FLAG    = 7;
  localparam int BIT_IE      = 6;
  localparam int MODE_LSB    = 2;

  // byte address of a channel's control word
  function automatic logic [31:0] ctl_addr(input int n);
    return 32'(8 * (n + 1));
  endfunction

  // byte address of a channel's compare word
  function automatic logic [31:0] cmp_addr(input int n);
    return 32'(8 * (n + 1) + 4);
  endfunction

  // control word readback layout
  function automatic logic [31:0] pack_ctl(input logic flag, input logic ie,
                                           input logic [3:0] mode);
    logic [31:0] v;
    v = '0;
    v[BIT_FLAG] = flag;
    v[BIT_IE] = ie;
    v[MODE_LSB +: 4] = mode;
    return v;
  endfunction
endpackage

// File: rtl/cmp_decode.sv
module cmp_decode #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [AW-1:0] addr,
  output logic [NCH-1:0] ctl_we,
  output logic [NCH-1:0] cmp_we
);
  import cmpbank_pkg::*;

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    localparam logic [AW-1:0] CTL_A = AW'(ctl_addr(n));
    localparam logic [AW-1:0] CMP_A = AW'(cmp_addr(n));
    assign ctl_we[n] = wr_en && (addr == CTL_A);
    assign cmp_we[n] = wr_en && (addr == CMP_A);
  end

  // R2: one register written per cycle at most
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_we, cmp_we}));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          ctl_we,
  input  logic [3:0]    wr_mode,
  input  logic          wr_ie,
  input  logic          wr_fclr,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wd,
  output logic          flag_o,
  output logic          ie_o,
  output logic [3:0]    mode_o,
  output logic          pin_o,
  output logic [CW-1:0] cmp_rd,
  output logic          hit_o
);
  import cmpbank_pkg::*;

  logic [3:0]    mode_q;
  logic          ie_q, flag_q, pin_q;
  logic [CW-1:0] act_q, nxt_q;
  logic          act_vld, nxt_vld;
  logic          hit, flush;

  assign hit   = (mode_q != MODE_OFF) && act_vld && (cnt_i == act_q);
  assign flush = ctl_we && (wr_mode == MODE_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
      act_q   <= '0;
      nxt_q   <= '0;
      act_vld <= 1'b0;
      nxt_vld <= 1'b0;
    end else begin
      flag_q <= hit | (flag_q & ~(ctl_we & wr_fclr));
      if (ctl_we) begin
        mode_q <= wr_mode;
        ie_q   <= wr_ie;
      end
      if (flush) begin
        act_vld <= 1'b0;
        nxt_vld <= 1'b0;
        pin_q   <= 1'b0;
      end else begin
        if (hit) begin
          if (cmp_we) begin
            if (nxt_vld) begin
              act_q <= nxt_q;
              nxt_q <= cmp_wd;
            end else begin
              act_q <= cmp_wd;
            end
          end else if (nxt_vld) begin
            act_q   <= nxt_q;
            nxt_vld <= 1'b0;
          end else begin
            act_vld <= 1'b0;
          end
        end else if (cmp_we) begin
          if (!act_vld) begin
            act_q   <= cmp_wd;
            act_vld <= 1'b1;
          end else begin
            nxt_q   <= cmp_wd;
            nxt_vld <= 1'b1;
          end
        end
        if (mode_q == MODE_PULSE) pin_q <= hit;
        else if (mode_q == MODE_TOGGLE && hit) pin_q <= ~pin_q;
      end
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign mode_o = mode_q;
  assign pin_o  = pin_q;
  assign cmp_rd = act_vld ? act_q : '0;
  assign hit_o  = hit;

  // R6: a match always leaves the flag set
  p_flag_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R4: a queued value never exists without an active one
  p_queue_behind_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_vld |-> act_vld);
  // R5: a mode-off write leaves the channel empty
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!act_vld && !nxt_vld && !pin_q));
  // R7: pulse lasts one cycle unless another match follows
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PULSE && !hit && !ctl_we) |=> !pin_q);
  // R8: toggle mode inverts the pin on a match
  p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TOGGLE && hit && !ctl_we) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/cmp_rdmux.sv
module cmp_rdmux #(
  parameter int NCH = 4,
  parameter int CW  = 31,
  parameter int AW  = 8
) (
  input  logic [AW-1:0]             addr,
  input  logic [NCH-1:0]            flags,
  input  logic [NCH-1:0][31:0]      ctl_rd,
  input  logic [NCH-1:0][CW-1:0]    cmp_rd,
  output logic [31:0]               rdata
);
  import cmpbank_pkg::*;

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = 32'(flags);
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(ctl_addr(n))) rdata = ctl_rd[n];
      if (addr == AW'(cmp_addr(n))) rdata = 32'(cmp_rd[n]);
    end
  end
endmodule

// File: rtl/cmp_bank.sv
module cmp_bank #(
  parameter int NCH = 4,
  parameter int CW  = 31,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cnt_i,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] irq_o
);
  import cmpbank_pkg::*;

  logic [NCH-1:0]          ctl_we, cmp_we, flags, ies, hits;
  logic [NCH-1:0][31:0]    ctl_rd;
  logic [NCH-1:0][CW-1:0]  cmp_rd;
  logic [CW-1:0]           cmp_wd;

  assign cmp_wd = wdata[CW-1:0];

  if (CW < 32) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[31:CW];
  end

  cmp_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .ctl_we(ctl_we), .cmp_we(cmp_we)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [3:0] mode_n;
    cmp_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
      .ctl_we(ctl_we[n]), .wr_mode(wdata[MODE_LSB +: 4]),
      .wr_ie(wdata[BIT_IE]), .wr_fclr(wdata[BIT_FLAG]),
      .cmp_we(cmp_we[n]), .cmp_wd(cmp_wd),
      .flag_o(flags[n]), .ie_o(ies[n]), .mode_o(mode_n),
      .pin_o(pin_o[n]), .cmp_rd(cmp_rd[n]), .hit_o(hits[n])
    );
    assign ctl_rd[n] = pack_ctl(flags[n], ies[n], mode_n);
    assign irq_o[n]  = flags[n] & ies[n];

    // R9: no interrupt on a channel whose flag is clear
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[n] |-> !irq_o[n]);
    // R6: a match raises the interrupt next cycle when enabled
    p_irq_after_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hits[n] && ies[n] && !ctl_we[n]) |=> irq_o[n]);
  end

  cmp_rdmux #(.NCH(NCH), .CW(CW), .AW(AW)) u_rd (
    .addr(addr), .flags(flags), .ctl_rd(ctl_rd), .cmp_rd(cmp_rd), .rdata(rdata)
  );
endmodule

// File: tb/cmp_bank_tb.sv
module cmp_bank_tb;
  localparam int NCH = 4;
  localparam int CW  = 31;
  localparam int AW  = 8;
  localparam logic [31:0] MSK = 32'h7FFF_FFFF;
  localparam logic [31:0] SEC = 32'd1_000_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cnt_i = 31'd1;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pin_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_o(pin_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] ctlv(input logic f, input logic ie, input logic [3:0] m);
    return {24'd0, f, ie, m, 2'b00};
  endfunction
  function automatic logic [7:0] a_ctl(input int n); return 8'(8 + 8 * n); endfunction
  function automatic logic [7:0] a_cmp(input int n); return 8'(12 + 8 * n); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    cnt_i = c[CW-1:0]; addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_at(a, d, 32'(cnt_i));
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #0.5; v = rdata;
  endtask

  task automatic step(input logic [31:0] c);
    @(negedge clk);
    cnt_i = c[CW-1:0];
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] t [0:5];
    int np;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 global", v, 0);
    for (int n = 0; n < NCH; n++) begin
      rd(a_ctl(n), v); chk("R1 ctl", v, 0);
      rd(a_cmp(n), v); chk("R1 cmp", v, 0);
    end
    chk("R1 pins", 32'(pin_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R3 masking, R5 flush on mode 0
    wr(a_cmp(0), 32'hFFFF_FFFF);
    rd(a_cmp(0), v); chk("R3 mask", v, 32'h7FFF_FFFF);
    wr(a_ctl(0), 0);
    rd(a_cmp(0), v); chk("R5 flush readback", v, 0);

    // R5 channel 3: flushed slots never match
    wr(a_cmp(3), 40); wr(a_cmp(3), 42);
    wr(a_ctl(3), ctlv(0, 0, 4'hF));
    wr(a_ctl(3), 0);
    wr(a_ctl(3), ctlv(0, 0, 4'hF));
    step(40); step(42);
    rd(a_ctl(3), v); chk("R5 no match after flush", v, ctlv(0, 0, 4'hF));
    wr(a_ctl(3), 0);
    wr(a_cmp(3), 44);
    step(44);
    rd(a_ctl(3), v); chk("R5 mode0 no flag", v, 0);
    wr(a_ctl(3), ctlv(0, 0, 4'hF));
    step(44);
    chk("R7 pulse high", 32'(pin_o[3]), 1);
    chk("R9 irq masked", 32'(irq_o[3]), 0);
    step(45);
    chk("R7 pulse one cycle", 32'(pin_o[3]), 0);
    rd(a_ctl(3), v); chk("R2 R6 ctl flag", v, ctlv(1, 0, 4'hF));
    wr(a_ctl(3), ctlv(1, 0, 4'hF));
    rd(a_ctl(3), v); chk("R6 w1c", v, ctlv(0, 0, 4'hF));

    // R8 toggle on channel 1
    wr(a_ctl(1), 0);
    wr(a_cmp(1), 50); wr(a_cmp(1), 60);
    wr(a_ctl(1), ctlv(0, 1, 4'h5));
    step(50);
    chk("R8 toggle up", 32'(pin_o[1]), 1);
    chk("R9 irq on", 32'(irq_o[1]), 1);
    step(51);
    chk("R8 hold", 32'(pin_o[1]), 1);
    step(60);
    chk("R8 toggle down", 32'(pin_o[1]), 0);
    rd(a_cmp(1), v); chk("R4 empty after last", v, 0);
    wr(a_ctl(1), ctlv(1, 1, 4'h5));
    chk("R9 irq off", 32'(irq_o[1]), 0);
    step(60);
    rd(a_ctl(1), v); chk("R4 empty no match", v, ctlv(0, 1, 4'h5));
    wr(a_cmp(1), 70);
    step(70);
    chk("R8 toggle again", 32'(pin_o[1]), 1);
    wr(a_ctl(1), ctlv(1, 0, 4'h0));
    chk("R8 mode0 pin low", 32'(pin_o[1]), 0);

    // R10 write and match in the same cycle, R6 clear vs match
    wr(a_ctl(2), 0);
    wr(a_cmp(2), 500);
    wr(a_ctl(2), ctlv(0, 1, 4'hF));
    wr_at(a_cmp(2), 700, 500);
    chk("R10 pulse", 32'(pin_o[2]), 1);
    rd(a_cmp(2), v); chk("R10 written becomes active", v, 700);
    step(501);
    wr_at(a_ctl(2), ctlv(1, 1, 4'hF), 700);
    rd(a_ctl(2), v); chk("R6 set beats clear", v, ctlv(1, 1, 4'hF));
    chk("R10 second match pulse", 32'(pin_o[2]), 1);
    chk("R9 irq ch2", 32'(irq_o[2]), 1);
    rd(8'h00, v); chk("R2 global mirror", v, 32'h4);

    // R4 R7 R9 pulse-per-second trains across the counter wrap on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      t[0] = (32'h8000_0000 - 32'd500_000_000 + 32'(3 * ch)) & MSK;
      for (int k = 1; k < 6; k++) t[k] = (t[k-1] + SEC) & MSK;
      step(1);
      wr(a_ctl(ch), ctlv(1, 0, 4'h0));
      rd(a_ctl(ch), v); chk("R5 mode reads zero", v, 0);
      wr(a_cmp(ch), t[0]);
      wr(a_ctl(ch), ctlv(0, 1, 4'hF));
      wr(a_cmp(ch), t[1]);
      for (int k = 0; k < 4; k++) begin
        np = 0;
        for (int i = 0; i < 5; i++) begin
          step((t[k] + 32'(i) - 32'd2) & MSK);
          if (pin_o[ch]) begin
            np++;
            chk("R7 pulse position", 32'(i), 2);
          end
        end
        chk("R7 single pulse", 32'(np), 1);
        chk("R9 irq raised", 32'(irq_o[ch]), 1);
        rd(a_cmp(ch), v); chk("R4 queued promoted", v, t[k+1]);
        wr(a_ctl(ch), ctlv(1, 1, 4'hF));
        chk("R9 irq cleared", 32'(irq_o[ch]), 0);
        wr(a_cmp(ch), t[k+2]);
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule